// File: doc/BRIEF.md
# Multiprocessor-Format Serial Transmitter

This block serialises bytes onto a single line using an asynchronous frame with one extra bit after the data. That bit tags the frame as an address (ID) frame or an ordinary data frame. A host places a byte and its tag bit into a one-entry holding register with a single-cycle write strobe. When the shifter is free, the block moves the entry into the shifter and starts the frame.

Two flags report progress. The empty flag says the holding register can take another byte. The end flag says the line has gone quiet after the last frame. Each flag drives a request output that is gated by its own enable. A free-running clock-enable input, one pulse per bit time, sets the bit rate. When the host refills the holding register before the current stop bit finishes, the next start bit follows the stop bit with no idle gap.

Top module: `mpFrameTx`

## Requirements
- R1: A frame on `serialOut` is a start bit 0, then the 8 bits of `wrData` with bit 0 first, then the `wrMpb` value, then a stop bit 1. `serialOut` only changes on the clock edge where `baudTick` is 1, so each bit lasts one tick interval.
- R2: A write (`wrEn`=1 at a clock edge) stores `wrData`/`wrMpb` and makes `holdEmpty` 0 after that edge.
- R3: When `holdEmpty` is 0 and no frame is in progress, the next edge copies the entry into the shifter and sets `holdEmpty` to 1. The first `baudTick` edge after that drives the start bit.
- R4: `txReadyReq` is 1 exactly when `holdEmpty` is 1 and `txReadyIrqEn` is 1.
- R5: If `holdEmpty` is 0 on the tick edge that ends a stop bit, that same edge drives the next frame's start bit and sets `holdEmpty` to 1, so no idle bit appears between frames.
- R6: If `holdEmpty` is 1 on the tick edge that ends a stop bit, `txEnd` becomes 1 and `serialOut` stays 1 (mark).
- R7: `txEndReq` is 1 exactly when `txEnd` is 1 and `txEndIrqEn` is 1.
- R8: A write makes `txEnd` 0 after that edge.
- R9: A second write while `holdEmpty` is 0 replaces the pending byte and tag bit. The frame already in the shifter is not affected.
- R10: After reset, `serialOut`=1, `holdEmpty`=1, `txEnd`=1 and no frame is in progress.
- R11: Tick pulses with no pending data leave `serialOut` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baudTick | input | 1 | One-cycle pulse per bit time |
| wrEn | input | 1 | Holding-register write strobe |
| wrData | input | 8 | Byte to send |
| wrMpb | input | 1 | Tag bit: 1 = ID frame, 0 = data frame |
| txReadyIrqEn | input | 1 | Enable for the ready request |
| txEndIrqEn | input | 1 | Enable for the end request |
| serialOut | output | 1 | Serial line, idle high |
| holdEmpty | output | 1 | Holding register free |
| txEnd | output | 1 | Line idle after the last frame |
| txReadyReq | output | 1 | Ready request |
| txEndReq | output | 1 | End request |

## Verification
`holdEmpty` and `txEnd` respond on the edge after a write. A transfer from an idle shifter sets `holdEmpty` one edge after it was seen at 0. `serialOut` moves only on the edge that samples `baudTick`, and the end-of-frame decision lands on that same edge. Both requests follow their flags in the same cycle. The bench steps a behavioural model at every rising edge with the inputs that the edge samples. It compares all five outputs at the following falling edge, so every result is read one register stage after its cause and never at the edge that produces it.

// File: rtl/mpTxPkg.sv
package mpTxPkg;
  // Strobes from control to datapath, one clock wide.
  typedef struct packed {
    logic holdWrite;  // capture host byte and tag bit
    logic loadIdle;   // fill shifter from the holding register, line untouched
    logic loadChain;  // fill shifter and drive the start bit at once
    logic shiftBit;   // put the next frame bit on the line
    logic goMark;     // frame finished, force the line high
  } txStrobeT;
endpackage

// File: rtl/mpTxControl.sv
module mpTxControl
  import mpTxPkg::*;
#(
  parameter int FRAME_LEN = 11
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     baudTick,
  input  logic     wrEn,
  output txStrobeT stb,
  output logic     holdEmpty,
  output logic     txEnd
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  logic             busy;
  logic [CNT_W-1:0] bitCnt;  // bits already driven in the current frame
  logic             xferIdle, atStop, endTick, chainGo, finishGo, shiftGo;

  always_comb begin
    xferIdle = !busy && !holdEmpty;
    atStop   = busy && (bitCnt == CNT_W'(FRAME_LEN));
    endTick  = atStop && baudTick;
    chainGo  = endTick && !holdEmpty;
    finishGo = endTick && holdEmpty;
    shiftGo  = busy && baudTick && !atStop;

    stb.holdWrite = wrEn;
    stb.loadIdle  = xferIdle;
    stb.loadChain = chainGo;
    stb.shiftBit  = shiftGo;
    stb.goMark    = finishGo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      bitCnt    <= '0;
      holdEmpty <= 1'b1;
      txEnd     <= 1'b1;
    end else begin
      if (xferIdle)      busy <= 1'b1;
      else if (finishGo) busy <= 1'b0;

      if (xferIdle)     bitCnt <= '0;
      else if (chainGo) bitCnt <= CNT_W'(1);
      else if (shiftGo) bitCnt <= bitCnt + CNT_W'(1);

      // a host write wins over a transfer on the same edge
      if (wrEn)                      holdEmpty <= 1'b0;
      else if (xferIdle || chainGo)  holdEmpty <= 1'b1;

      if (wrEn)          txEnd <= 1'b0;
      else if (finishGo) txEnd <= 1'b1;
    end
  end
endmodule

// File: rtl/mpTxDatapath.sv
module mpTxDatapath
  import mpTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  txStrobeT          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrMpb,
  output logic              lineOut
);
  localparam int FRAME_LEN = DATA_W + 3;

  logic [DATA_W-1:0]    holdData;
  logic                 holdMpb;
  logic [FRAME_LEN-1:0] frameWord;
  logic [FRAME_LEN-1:0] shiftReg;

  // stop, tag, data (bit 0 nearest the start bit), start
  assign frameWord = {1'b1, holdMpb, holdData, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      holdData <= '0;
      holdMpb  <= 1'b0;
    end else if (stb.holdWrite) begin
      holdData <= wrData;
      holdMpb  <= wrMpb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '1;
      lineOut  <= 1'b1;
    end else if (stb.loadIdle) begin
      shiftReg <= frameWord;
    end else if (stb.loadChain) begin
      shiftReg <= {1'b1, frameWord[FRAME_LEN-1:1]};
      lineOut  <= frameWord[0];
    end else if (stb.shiftBit) begin
      shiftReg <= {1'b1, shiftReg[FRAME_LEN-1:1]};
      lineOut  <= shiftReg[0];
    end else if (stb.goMark) begin
      lineOut  <= 1'b1;
    end
  end
endmodule

// File: rtl/mpFrameTx.sv
module mpFrameTx
  import mpTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baudTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrMpb,
  input  logic              txReadyIrqEn,
  input  logic              txEndIrqEn,
  output logic              serialOut,
  output logic              holdEmpty,
  output logic              txEnd,
  output logic              txReadyReq,
  output logic              txEndReq
);
  localparam int FRAME_LEN = DATA_W + 3;

  txStrobeT stb;

  mpTxControl #(.FRAME_LEN(FRAME_LEN)) ctrl_i (
    .clk(clk), .rst(rst), .baudTick(baudTick), .wrEn(wrEn),
    .stb(stb), .holdEmpty(holdEmpty), .txEnd(txEnd)
  );

  mpTxDatapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData), .wrMpb(wrMpb),
    .lineOut(serialOut)
  );

  assign txReadyReq = holdEmpty && txReadyIrqEn;
  assign txEndReq   = txEnd && txEndIrqEn;
endmodule

// File: rtl/mpFrameTxChecker.sv
module mpFrameTxChecker (
  input logic clk,
  input logic rst,
  input logic baudTick,
  input logic wrEn,
  input logic serialOut,
  input logic holdEmpty,
  input logic txEnd
);
  p_write_clears_empty_r2: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !holdEmpty);

  p_write_clears_end_r8: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !txEnd);

  p_line_moves_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
    !baudTick |=> $stable(serialOut));

  p_end_holds_mark_r6: assert property (@(posedge clk) disable iff (rst)
    txEnd |-> serialOut);

  p_reset_state_r10: assert property (@(posedge clk)
    $past(rst) |-> (serialOut && holdEmpty && txEnd));
endmodule

bind mpFrameTx mpFrameTxChecker chk_i (
  .clk(clk), .rst(rst), .baudTick(baudTick), .wrEn(wrEn),
  .serialOut(serialOut), .holdEmpty(holdEmpty), .txEnd(txEnd)
);

// File: tb/mpFrameTx_tb_top.sv
`timescale 1ns/1ps
module mpFrameTx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baudTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrMpb = 1'b0;
  logic       txReadyIrqEn = 1'b0;
  logic       txEndIrqEn = 1'b0;
  logic       serialOut, holdEmpty, txEnd, txReadyReq, txEndReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tickMode = 0;   // 0: every 4 cycles, 1: every cycle, 2: pseudo-random
  int tickCnt = 0;
  logic [7:0] lfsr = 8'hA5;
  bit compareOn = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mpFrameTx dut_i (
    .clk(clk), .rst(rst), .baudTick(baudTick), .wrEn(wrEn), .wrData(wrData),
    .wrMpb(wrMpb), .txReadyIrqEn(txReadyIrqEn), .txEndIrqEn(txEndIrqEn),
    .serialOut(serialOut), .holdEmpty(holdEmpty), .txEnd(txEnd),
    .txReadyReq(txReadyReq), .txEndReq(txEndReq)
  );

  // ---------------- behavioural reference ----------------
  bit mLine = 1, mEmpty = 1, mEnd = 1, mBusy = 0;
  int mSent = 0;
  bit mQ[$];
  bit [7:0] pData = 0;
  bit pMpb = 0;

  task automatic buildFrame();
    mQ.delete();
    mQ.push_back(1'b0);
    for (int i = 0; i < 8; i++) mQ.push_back(pData[i]);
    mQ.push_back(pMpb);
    mQ.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    bit nEmpty, nEnd;
    if (rst) begin
      mLine = 1; mEmpty = 1; mEnd = 1; mBusy = 0; mSent = 0; mQ.delete();
    end else begin
      nEmpty = mEmpty; nEnd = mEnd;
      if (!mBusy && !mEmpty) begin
        buildFrame(); mBusy = 1; mSent = 0; nEmpty = 1;
      end else if (mBusy && baudTick) begin
        if (mSent == 11) begin
          if (!mEmpty) begin
            buildFrame(); mLine = mQ.pop_front(); mSent = 1; nEmpty = 1;  // back to back
          end else begin
            mBusy = 0; mLine = 1; nEnd = 1;
          end
        end else begin
          mLine = mQ.pop_front(); mSent++;
        end
      end
      if (wrEn) begin
        pData = wrData; pMpb = wrMpb; nEmpty = 0; nEnd = 0;
      end
      mEmpty = nEmpty; mEnd = nEnd;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (compareOn && !rst) begin
      check(serialOut == mLine, "R1/R5/R9 serialOut", serialOut, mLine);
      check(holdEmpty == mEmpty, "R2/R3 holdEmpty", holdEmpty, mEmpty);
      check(txEnd == mEnd, "R6/R8 txEnd", txEnd, mEnd);
      check(txReadyReq == (mEmpty && txReadyIrqEn), "R4 txReadyReq", txReadyReq, mEmpty && txReadyIrqEn);
      check(txEndReq == (mEnd && txEndIrqEn), "R7 txEndReq", txEndReq, mEnd && txEndIrqEn);
    end
  end

  // baud tick generator
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tickCnt <= (tickCnt == 3) ? 0 : tickCnt + 1;
    case (tickMode)
      0: baudTick <= (tickCnt == 3);
      1: baudTick <= 1'b1;
      default: baudTick <= lfsr[0] & lfsr[2];
    endcase
  end

  // watchdog
  always @(negedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic hostWrite(input logic [7:0] d, input logic m);
    @(negedge clk);
    #0.5;
    wrEn = 1'b1; wrData = d; wrMpb = m;
    @(negedge clk);
    #0.5;
    wrEn = 1'b0;
  endtask

  task automatic waitEnd();
    int n = 0;
    do begin
      @(negedge clk); n++;
    end while (!(txEnd && holdEmpty) && n < 5000);
    check(txEnd == 1'b1, "R6 frame end reached", txEnd, 1);
  endtask

  task automatic waitEmpty();
    int n = 0;
    do begin
      @(negedge clk); n++;
    end while (!holdEmpty && n < 5000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(serialOut == 1'b1, "R10 serialOut after reset", serialOut, 1);
    check(holdEmpty == 1'b1, "R10 holdEmpty after reset", holdEmpty, 1);
    check(txEnd == 1'b1, "R10 txEnd after reset", txEnd, 1);
    compareOn = 1'b1;

    // R11: ticks with nothing pending keep the line high
    repeat (20) @(negedge clk);
    check(serialOut == 1'b1, "R11 idle line", serialOut, 1);

    // R1/R3/R6/R7: single ID frame, both enables on
    txReadyIrqEn = 1'b1; txEndIrqEn = 1'b1;
    hostWrite(8'hA5, 1'b1);
    waitEnd();
    check(txEndReq == 1'b1, "R7 end request", txEndReq, 1);

    // R5/R8: back to back frames, writes kept ahead of the shifter
    hostWrite(8'h3C, 1'b0);
    waitEmpty();
    hostWrite(8'hC3, 1'b1);
    waitEmpty();
    hostWrite(8'h01, 1'b0);
    waitEnd();

    // R9: overwrite the pending entry while a frame is shifting
    txReadyIrqEn = 1'b0;
    hostWrite(8'hFF, 1'b0);
    waitEmpty();
    hostWrite(8'h11, 1'b1);
    hostWrite(8'h80, 1'b0);   // replaces 0x11
    waitEnd();

    // R4/R7 with enables off, tick every cycle
    txEndIrqEn = 1'b0;
    tickMode = 1;
    hostWrite(8'h5A, 1'b1);
    waitEmpty();
    hostWrite(8'h96, 1'b0);
    waitEnd();
    check(txEndReq == 1'b0, "R7 end request masked", txEndReq, 0);

    // irregular tick pattern, mixed traffic
    tickMode = 2;
    txReadyIrqEn = 1'b1; txEndIrqEn = 1'b1;
    for (int k = 0; k < 12; k++) begin
      hostWrite(8'(k * 37 + 5), k[0]);
      if (k % 4 == 3) waitEnd(); else waitEmpty();
    end
    waitEnd();
    repeat (30) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule